// File: doc/BRIEF.md
# Video Sync and Enable Conditioner

This block sits on the pixel clock after link recovery and cleans up the three video control bits before they leave the chip: horizontal sync (HS), vertical sync (VS) and data enable (DE). HS and DE pass through a minimum-width glitch stage, so a level that does not hold for three pixel clocks never reaches the output. A single configuration input turns that stage into a one-clock pass-through. Tying the input low leaves the glitch stage active, so the filter is on by default.

Each signal also has a rate guard, which is active whether or not the glitch stage is bypassed. VS may change at most once within any 130 clocks. HS and DE may each change at most twice within any 130 clocks. An output change that would break its limit is dropped. The output keeps its level, and a sticky violation flag for that signal is set. Only a synchronous reset clears the flags, the rate windows and the outputs.

Top module: `vidctl_filter`

## Requirements
- R1: While `bypass_i` is 0, a level on HS or DE that is sampled on fewer than 3 consecutive rising edges never appears on `hs_o` or `de_o`.
- R2: While `bypass_i` is 0, `hs_o` or `de_o` takes a new input level on the third consecutive rising edge that samples that level. This gives a fixed lag of 3 clocks.
- R3: While `bypass_i` is 1, `hs_o` and `de_o` take the input level on the first rising edge that samples it. A one-clock pulse passes as a one-clock pulse.
- R4: `vs_o` takes a new level on the first rising edge that samples it. If an input edge arrives fewer than 130 rising edges after the last accepted `vs_o` change, it is ignored. An input edge exactly 130 or more edges later is accepted.
- R5: `hs_o` and `de_o` each change at most twice within any 130 consecutive rising edges. A third change inside that window is ignored.
- R6: When an input transition is ignored by the rate guard, the flag for that signal (`hs_viol_o`, `vs_viol_o` or `de_viol_o`) goes to 1 after that edge. It stays at 1 until reset, and it leaves the flags of the other signals unchanged.
- R7: While `rst` is 1, all outputs and flags are 0 after each rising edge, and every rate window is emptied.
- R8: A change of `bypass_i` acts on the next rising edge. Toggling it while the inputs are steady produces no output edge. A level still pending in the glitch stage is committed at once when the bypass turns on.
- R9: After a transition has been ignored, the output keeps its level even after the window expires. It moves only when a later input transition is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| bypass_i | input | 1 | 1 skips the HS/DE minimum-width stage, 0 keeps it active |
| hs_i | input | 1 | Raw horizontal sync |
| vs_i | input | 1 | Raw vertical sync |
| de_i | input | 1 | Raw data enable |
| hs_o | output | 1 | Conditioned horizontal sync |
| vs_o | output | 1 | Conditioned vertical sync |
| de_o | output | 1 | Conditioned data enable |
| hs_viol_o | output | 1 | Sticky flag: an HS transition was dropped |
| vs_viol_o | output | 1 | Sticky flag: a VS transition was dropped |
| de_viol_o | output | 1 | Sticky flag: a DE transition was dropped |

## Verification
The glitch stage is driven with pulses of one, two and more than three clocks, which locates the width threshold. Held levels are sampled both one clock before and on the third edge, which confirms the exact lag. Bypass is tried with single-clock pulses and by toggling it mid-qualification and with steady inputs, which separates a correct bypass from one that drops pulses or creates edges. The VS window is probed with a second edge 129 and then 130 edges after the first, and HS is hit with three edges in a row followed by a long hold. Together these show the change-count limit, the window boundary, the absence of late catch-up and the per-signal stickiness of the flags.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;

    // Lane index of each control bit inside the internal vectors
    localparam int SIG_HS  = 0;
    localparam int SIG_VS  = 1;
    localparam int SIG_DE  = 2;
    localparam int NUM_SIG = 3;

endpackage

// File: rtl/vidctl_width_filt.sv
module vidctl_width_filt #(
    parameter int MIN_WIDTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic bypass,
    input  logic din,
    output logic dout
);

    localparam int CW = $clog2(MIN_WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_WIDTH - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } wf_state_t;

    wf_state_t st_d, st_q;

    // dout is the level that the downstream stage registers on this edge
    always_comb begin
        st_d = st_q;
        dout = st_q.lvl;
        if (bypass) begin
            st_d.lvl = din;
            st_d.cnt = '0;
            dout     = din;
        end else if (din == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.lvl = din;
            st_d.cnt = '0;
            dout     = din;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Checker: length of the run of equal input samples, independent of cnt
    logic [CW-1:0] run_q, run_now;
    logic          prev_q;

    always_comb begin
        if (din != prev_q) begin
            run_now = CW'(1);
        end else if (run_q == CW'(MIN_WIDTH)) begin
            run_now = run_q;
        end else begin
            run_now = run_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            run_q  <= run_now;
            prev_q <= din;
        end
    end

    // R1 / R2: with the stage active, a new level passes only after a full run
    a_r1_min_hold: assert property (@(posedge clk) disable iff (rst)
        (!bypass && dout != st_q.lvl) |-> (run_now >= CW'(MIN_WIDTH)))
        else $error("a_r1_min_hold");

endmodule

// File: rtl/vidctl_rate_lim.sv
module vidctl_rate_lim #(
    parameter int WINDOW    = 130,
    parameter int MAX_EDGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic viol
);

    localparam int TW = $clog2(WINDOW + 1);
    localparam int AW = $clog2(WINDOW + 1);
    localparam logic [TW-1:0] RELOAD = TW'(WINDOW - 1);
    localparam logic [AW-1:0] AGE_MAX = AW'(WINDOW);

    typedef struct packed {
        logic                          out;
        logic                          prev;
        logic                          viol;
        logic [MAX_EDGES-1:0][TW-1:0]  tmr;
    } rl_state_t;

    rl_state_t st_d, st_q;
    logic      claimed;

    // One countdown per permitted change; a busy timer marks a change
    // still inside the window
    always_comb begin
        st_d      = st_q;
        st_d.prev = din;
        claimed   = 1'b0;
        for (int i = 0; i < MAX_EDGES; i++) begin
            if (st_q.tmr[i] != '0) begin
                st_d.tmr[i] = st_q.tmr[i] - TW'(1);
            end
        end
        if (din != st_q.prev && din != st_q.out) begin
            for (int i = 0; i < MAX_EDGES; i++) begin
                if (!claimed && st_q.tmr[i] == '0) begin
                    claimed     = 1'b1;
                    st_d.tmr[i] = RELOAD;
                end
            end
            if (claimed) begin
                st_d.out = din;
            end else begin
                st_d.viol = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.out;
    assign viol = st_q.viol;

    // Checker: ages of the most recent output changes, saturating at WINDOW
    logic [MAX_EDGES-1:0][AW-1:0] age_q, age_d;
    logic                         chg;

    assign chg = (st_d.out != st_q.out);

    always_comb begin
        for (int i = 0; i < MAX_EDGES; i++) begin
            age_d[i] = (age_q[i] == AGE_MAX) ? age_q[i] : age_q[i] + AW'(1);
        end
        if (chg) begin
            for (int i = MAX_EDGES - 1; i > 0; i--) begin
                age_d[i] = (age_q[i-1] == AGE_MAX) ? age_q[i-1] : age_q[i-1] + AW'(1);
            end
            age_d[0] = AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAX_EDGES; i++) begin
                age_q[i] <= AGE_MAX;
            end
        end else begin
            age_q <= age_d;
        end
    end

    // R4 / R5: a change is allowed only if the oldest tracked change left the window
    a_r4_r5_rate_window: assert property (@(posedge clk) disable iff (rst)
        chg |-> (age_q[MAX_EDGES-1] >= AGE_MAX))
        else $error("a_r4_r5_rate_window");

    // R6: the violation flag never drops outside reset
    a_r6_viol_sticky: assert property (@(posedge clk) disable iff (rst)
        st_q.viol |=> st_q.viol)
        else $error("a_r6_viol_sticky");

endmodule

// File: rtl/vidctl_filter.sv
module vidctl_filter
    import vidctl_pkg::*;
#(
    parameter int MIN_WIDTH       = 3,
    parameter int WINDOW          = 130,
    parameter int LINE_MAX_EDGES  = 2,
    parameter int FRAME_MAX_EDGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic bypass_i,
    input  logic hs_i,
    input  logic vs_i,
    input  logic de_i,
    output logic hs_o,
    output logic vs_o,
    output logic de_o,
    output logic hs_viol_o,
    output logic vs_viol_o,
    output logic de_viol_o
);

    logic [NUM_SIG-1:0] raw;
    logic [NUM_SIG-1:0] shaped;
    logic [NUM_SIG-1:0] clean;
    logic [NUM_SIG-1:0] viol;

    assign raw[SIG_HS] = hs_i;
    assign raw[SIG_VS] = vs_i;
    assign raw[SIG_DE] = de_i;

    for (genvar g = 0; g < NUM_SIG; g++) begin : g_sig
        localparam int ME = (g == SIG_VS) ? FRAME_MAX_EDGES : LINE_MAX_EDGES;

        if (g == SIG_VS) begin : g_frame
            assign shaped[g] = raw[g];
        end else begin : g_line
            vidctl_width_filt #(
                .MIN_WIDTH (MIN_WIDTH)
            ) u_width (
                .clk    (clk),
                .rst    (rst),
                .bypass (bypass_i),
                .din    (raw[g]),
                .dout   (shaped[g])
            );
        end

        vidctl_rate_lim #(
            .WINDOW    (WINDOW),
            .MAX_EDGES (ME)
        ) u_rate (
            .clk  (clk),
            .rst  (rst),
            .din  (shaped[g]),
            .dout (clean[g]),
            .viol (viol[g])
        );
    end

    assign hs_o      = clean[SIG_HS];
    assign vs_o      = clean[SIG_VS];
    assign de_o      = clean[SIG_DE];
    assign hs_viol_o = viol[SIG_HS];
    assign vs_viol_o = viol[SIG_VS];
    assign de_viol_o = viol[SIG_DE];

    // R3: in bypass, any HS edge lands on the level sampled one edge earlier
    a_r3_hs_bypass_follow: assert property (@(posedge clk) disable iff (rst)
        ($past(bypass_i) && hs_o != $past(hs_o)) |-> (hs_o == $past(hs_i)))
        else $error("a_r3_hs_bypass_follow");

    // R3: same for DE
    a_r3_de_bypass_follow: assert property (@(posedge clk) disable iff (rst)
        ($past(bypass_i) && de_o != $past(de_o)) |-> (de_o == $past(de_i)))
        else $error("a_r3_de_bypass_follow");

    // R7: reset leaves every output and flag low
    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> ({hs_o, vs_o, de_o, hs_viol_o, vs_viol_o, de_viol_o} == 6'b0))
        else $error("a_r7_reset_clear");

endmodule

// File: tb/vidctl_filter_bench.sv
module vidctl_filter_bench;

    logic clk = 1'b0;
    logic rst, bypass_i, hs_i, vs_i, de_i;
    logic hs_o, vs_o, de_o, hs_viol_o, vs_viol_o, de_viol_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    vidctl_filter u_vidctl_filter (
        .clk       (clk),
        .rst       (rst),
        .bypass_i  (bypass_i),
        .hs_i      (hs_i),
        .vs_i      (vs_i),
        .de_i      (de_i),
        .hs_o      (hs_o),
        .vs_o      (vs_o),
        .de_o      (de_o),
        .hs_viol_o (hs_viol_o),
        .vs_viol_o (vs_viol_o),
        .de_viol_o (de_viol_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; bypass_i = 1'b0; hs_i = 1'b0; vs_i = 1'b0; de_i = 1'b0;
        step(2);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        rst = 1'b1; bypass_i = 1'b0; hs_i = 1'b1; vs_i = 1'b1; de_i = 1'b1;
        step(2);
        check("R7", "hs_o in reset", hs_o, 1'b0);
        check("R7", "vs_o in reset", vs_o, 1'b0);
        check("R7", "de_o in reset", de_o, 1'b0);
        check("R7", "flags in reset", hs_viol_o | vs_viol_o | de_viol_o, 1'b0);
        rst = 1'b0;
        step(1);
        check("R4", "vs_o after one edge", vs_o, 1'b1);
        check("R2", "hs_o after one edge", hs_o, 1'b0);
        step(2);
        check("R2", "hs_o after three edges", hs_o, 1'b1);
        check("R2", "de_o after three edges", de_o, 1'b1);
    endtask

    task automatic t_glitch();
        do_reset();
        hs_i = 1'b1;
        step(2);
        hs_i = 1'b0; de_i = 1'b1;
        step(1);
        de_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            step(1);
            check("R1", "hs_o after 2-clock pulse", hs_o, 1'b0);
            check("R1", "de_o after 1-clock pulse", de_o, 1'b0);
        end
        check("R1", "no hs flag from glitch", hs_viol_o, 1'b0);
    endtask

    task automatic t_lag();
        do_reset();
        de_i = 1'b1;
        step(2);
        check("R2", "de_o before third edge", de_o, 1'b0);
        step(1);
        check("R2", "de_o on third edge", de_o, 1'b1);
        step(7);
        de_i = 1'b0;
        step(2);
        check("R2", "de_o fall before third edge", de_o, 1'b1);
        step(1);
        check("R2", "de_o fall on third edge", de_o, 1'b0);
        check("R5", "two DE changes allowed", de_viol_o, 1'b0);
    endtask

    task automatic t_bypass();
        do_reset();
        bypass_i = 1'b1;
        hs_i = 1'b1;
        step(1);
        check("R3", "hs_o rise one edge", hs_o, 1'b1);
        hs_i = 1'b0;
        step(1);
        check("R3", "hs_o fall one edge", hs_o, 1'b0);
    endtask

    task automatic t_vs_window();
        do_reset();
        vs_i = 1'b1;
        step(1);
        check("R4", "vs_o first rise", vs_o, 1'b1);
        step(49);
        vs_i = 1'b0;
        step(1);
        check("R4", "early vs fall ignored", vs_o, 1'b1);
        check("R6", "vs flag set", vs_viol_o, 1'b1);
        check("R6", "hs flag untouched", hs_viol_o, 1'b0);
        vs_i = 1'b1;
        step(89);
        vs_i = 1'b0;
        step(1);
        check("R4", "late vs fall accepted", vs_o, 1'b0);
        check("R6", "vs flag still set", vs_viol_o, 1'b1);
    endtask

    task automatic t_vs_boundary();
        do_reset();
        vs_i = 1'b1;
        step(129);
        vs_i = 1'b0;
        step(1);
        check("R4", "vs change at 129 edges ignored", vs_o, 1'b1);
        check("R6", "vs flag at 129 edges", vs_viol_o, 1'b1);
        do_reset();
        vs_i = 1'b1;
        step(130);
        vs_i = 1'b0;
        step(1);
        check("R4", "vs change at 130 edges accepted", vs_o, 1'b0);
        check("R4", "no vs flag at 130 edges", vs_viol_o, 1'b0);
    endtask

    task automatic t_line_rate();
        do_reset();
        bypass_i = 1'b1;
        hs_i = 1'b1; step(1);
        hs_i = 1'b0; step(1);
        hs_i = 1'b1; step(1);
        check("R5", "third hs change ignored", hs_o, 1'b0);
        check("R6", "hs flag set", hs_viol_o, 1'b1);
        check("R6", "de flag untouched", de_viol_o, 1'b0);
        check("R6", "vs flag untouched", vs_viol_o, 1'b0);
        step(200);
        check("R9", "no catch-up after window", hs_o, 1'b0);
        hs_i = 1'b0; step(1);
        check("R9", "edge to current level", hs_o, 1'b0);
        hs_i = 1'b1; step(1);
        check("R9", "next edge accepted", hs_o, 1'b1);
        check("R6", "hs flag sticky", hs_viol_o, 1'b1);
        rst = 1'b1; step(1);
        check("R7", "reset clears hs flag", hs_viol_o, 1'b0);
        check("R7", "reset clears hs_o", hs_o, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_enable_switch();
        do_reset();
        hs_i = 1'b1;
        step(1);
        bypass_i = 1'b1;
        step(1);
        check("R8", "pending level committed by bypass", hs_o, 1'b1);
        bypass_i = 1'b0;
        step(5);
        check("R8", "steady hs after re-enable", hs_o, 1'b1);
        bypass_i = 1'b1; step(1);
        check("R8", "bypass on, steady input", hs_o, 1'b1);
        bypass_i = 1'b0; step(1);
        check("R8", "bypass off, steady input", hs_o, 1'b1);
        check("R8", "de untouched by toggles", de_o, 1'b0);
        hs_i = 1'b0;
        step(2);
        hs_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step(1);
            check("R8", "filter active again after toggle", hs_o, 1'b1);
        end
    endtask

    initial begin
        rst = 1'b1; bypass_i = 1'b0; hs_i = 1'b0; vs_i = 1'b0; de_i = 1'b0;
        t_reset_state();
        t_glitch();
        t_lag();
        t_bypass();
        t_vs_window();
        t_vs_boundary();
        t_line_rate();
        t_enable_switch();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule